// File: doc/BRIEF.md
# Speculative Store Buffer

This block collects the stores that a core issues inside a speculative critical section, so that the data cache stays untouched until the section ends. Each held entry keeps a word address, a data word and a byte mask. A later speculative store to an address that is already held merges into the existing entry. Loads look up the buffer and overlay the held bytes on the word read from the cache, so the core sees its own speculative writes.

An abort throws away every held entry and leaves the cache as it was. A commit copies the entries into the cache one per cycle, in the order they were allocated. For the whole copy the block raises a stall that stops incoming coherence traffic, so other agents see the update happen at once. Write permission for each address is granted before a store is accepted, so the copy never waits. Stores issued outside speculation go straight to the cache write port. When every entry is in use and a store to a new address arrives, the block raises an overflow request so the core can abort.

Top module: `spec_store_buf`

## Requirements
- R1: A store with `spec_i`=1 outside a drain is captured in the buffer, and `dc_we_o` stays 0 in that cycle.
- R2: A speculative store to an address already held updates only the bytes whose `st_be_i` bit is set and ORs its mask into the entry's mask. It allocates no new entry and is allowed even when the buffer is full.
- R3: With all DEPTH entries in use, a speculative store to an address not held drives `overflow_o`=1 in the same cycle and is dropped.
- R4: A load whose address matches a held entry returns, on `ld_data_o`, the held byte for each byte lane whose mask bit is set and the `ld_cache_data_i` byte in every other lane, with `ld_hit_o`=1. A load that matches nothing returns `ld_cache_data_i` unchanged with `ld_hit_o`=0. Byte lane b is bits 8b+7..8b.
- R5: `abort_i` outside a drain empties the buffer at the next edge and no cache write results. Abort takes priority over a commit or a store in the same cycle.
- R6: After a commit, every held entry is written to the cache port once, one per cycle, in allocation order, with its address, data and mask.
- R7: `coh_stall_o` is 1 in exactly the cycles in which an entry is being written during the drain, and is 0 at all other times, including after reset.
- R8: `commit_done_o` pulses for one cycle right after the last drain write, with `coh_stall_o` low and the buffer empty. A commit of an empty buffer pulses `commit_done_o` in the next cycle with no stall and no write.
- R9: A store with `spec_i`=0 appears on the cache write port in the same cycle and is not buffered.
- R10: A speculative store presented in the same cycle as `commit_i` is included in the drain. Stores and aborts presented during a drain are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spec_i | input | 1 | Core is inside a speculative section |
| st_valid_i | input | 1 | Store request valid |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/8 | Store byte enables |
| abort_i | input | 1 | Discard all speculative stores |
| commit_i | input | 1 | Start the commit drain |
| ld_addr_i | input | ADDR_W | Load word address |
| ld_cache_data_i | input | DATA_W | Word read from the data cache for this load |
| ld_data_o | output | DATA_W | Load data with buffered bytes overlaid |
| ld_hit_o | output | 1 | Load address matches a held entry |
| overflow_o | output | 1 | Buffer full and new address; requests abort |
| dc_we_o | output | 1 | Data cache write enable |
| dc_addr_o | output | ADDR_W | Data cache write address |
| dc_data_o | output | DATA_W | Data cache write data |
| dc_be_o | output | DATA_W/8 | Data cache write byte enables |
| coh_stall_o | output | 1 | Hold off incoming coherence messages |
| commit_done_o | output | 1 | One-cycle pulse when the commit drain ends |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both. In the first, a speculative store is raised in the same cycle as `commit_i`; the scoreboard expects that store's write as the last drain item, and the stall is expected to last exactly the number of entries. In the second, an abort is raised together with a store and a commit; the bench then expects no cache write at all, load misses on every earlier address, and an immediate done on the next commit. An abort and a store injected during a drain are judged in the same way: the drain must run to completion and the injected address must miss afterwards.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic {
    DRN_IDLE,
    DRN_BUSY
  } drain_state_e;
endpackage

// File: rtl/ssb_match.sv
module ssb_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] tags_i,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [ADDR_W-1:0]            key_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = (CNT_W'(g) < cnt_i) && (tags_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/ssb_fwd.sv
module ssb_fwd #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              hit_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic [BYTES-1:0]  ent_be_i,
  input  logic [DATA_W-1:0] cache_data_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign data_o[b*8 +: 8] = (hit_i && ent_be_i[b]) ? ent_data_i[b*8 +: 8]
                                                     : cache_data_i[b*8 +: 8];
  end
endmodule

// File: rtl/ssb_drain.sv
module ssb_drain
  import ssb_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic             has_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             last_o,
  output logic             done_o
);
  drain_state_e state_q;
  logic [IDX_W-1:0] ptr_q;
  logic done_q;

  assign busy_o = (state_q == DRN_BUSY);
  assign ptr_o  = ptr_q;
  assign last_o = busy_o && (CNT_W'(ptr_q) == cnt_i - CNT_W'(1));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DRN_IDLE;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        DRN_IDLE: begin
          if (commit_i && !abort_i) begin
            if (has_data_i) begin
              state_q <= DRN_BUSY;
              ptr_q   <= '0;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        default: begin
          if (last_o) begin
            state_q <= DRN_IDLE;
            ptr_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            ptr_q <= ptr_q + IDX_W'(1);
          end
        end
      endcase
    end
  end

  p_done_unstalled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_ptr_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (CNT_W'(ptr_q) < cnt_i));
  p_ptr_steps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spec_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [BYTES-1:0]  st_be_i,
  input  logic              abort_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_cache_data_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_hit_o,
  output logic              overflow_o,
  output logic              dc_we_o,
  output logic [ADDR_W-1:0] dc_addr_o,
  output logic [DATA_W-1:0] dc_data_o,
  output logic [BYTES-1:0]  dc_be_o,
  output logic              coh_stall_o,
  output logic              commit_done_o
);
  logic [DEPTH-1:0][ADDR_W-1:0] tag_q;
  logic [DEPTH-1:0][DATA_W-1:0] dat_q;
  logic [DEPTH-1:0][BYTES-1:0]  be_q;
  logic [CNT_W-1:0]             cnt_q;

  logic             st_hit, ld_hit;
  logic [IDX_W-1:0] st_idx, ld_idx, ptr, alloc_idx;
  logic             busy, last, done;
  logic             spec_st, full, alloc, merge, has_data;

  ssb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_st_match (
    .tags_i(tag_q), .cnt_i(cnt_q), .key_i(st_addr_i), .hit_o(st_hit), .idx_o(st_idx)
  );

  ssb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ld_match (
    .tags_i(tag_q), .cnt_i(cnt_q), .key_i(ld_addr_i), .hit_o(ld_hit), .idx_o(ld_idx)
  );

  // stores freeze while the drain runs
  assign spec_st    = st_valid_i && spec_i && !busy;
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign alloc      = spec_st && !st_hit && !full && !abort_i;
  assign merge      = spec_st && st_hit && !abort_i;
  assign overflow_o = spec_st && !st_hit && full;
  assign alloc_idx  = IDX_W'(cnt_q);
  assign has_data   = (cnt_q != '0) || alloc;

  ssb_drain #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_drain (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit_i), .abort_i(abort_i),
    .has_data_i(has_data), .cnt_i(cnt_q), .busy_o(busy), .ptr_o(ptr),
    .last_o(last), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (last || (abort_i && !busy)) begin
      cnt_q <= '0;
    end else if (alloc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc) begin
      tag_q[alloc_idx] <= st_addr_i;
      dat_q[alloc_idx] <= st_data_i;
      be_q[alloc_idx]  <= st_be_i;
    end else if (merge) begin
      be_q[st_idx] <= be_q[st_idx] | st_be_i;
      for (int b = 0; b < BYTES; b++) begin
        if (st_be_i[b]) dat_q[st_idx][b*8 +: 8] <= st_data_i[b*8 +: 8];
      end
    end
  end

  always_comb begin
    if (busy) begin
      dc_we_o   = 1'b1;
      dc_addr_o = tag_q[ptr];
      dc_data_o = dat_q[ptr];
      dc_be_o   = be_q[ptr];
    end else begin
      dc_we_o   = st_valid_i && !spec_i;
      dc_addr_o = st_addr_i;
      dc_data_o = st_data_i;
      dc_be_o   = st_be_i;
    end
  end

  ssb_fwd #(.DATA_W(DATA_W)) u_fwd (
    .hit_i(ld_hit), .ent_data_i(dat_q[ld_idx]), .ent_be_i(be_q[ld_idx]),
    .cache_data_i(ld_cache_data_i), .data_o(ld_data_o)
  );

  assign ld_hit_o      = ld_hit;
  assign coh_stall_o   = busy;
  assign commit_done_o = done;

  p_spec_no_cache_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && spec_i && !coh_stall_o) |-> !dc_we_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !abort_i) |=> (cnt_q == $past(cnt_q)));
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_abort_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !coh_stall_o) |=> (cnt_q == '0) && !coh_stall_o);
  p_stall_writes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coh_stall_o |-> dc_we_o);
  p_done_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done_o |-> (cnt_q == '0));
  p_drain_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coh_stall_o && !last) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: tb/spec_store_buf_bench.sv
module spec_store_buf_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BY = 4;
  localparam logic [31:0] CACHE = 32'hCAFEF00D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec, st_valid, abort, commit;
  logic [AW-1:0] st_addr, ld_addr, dc_addr;
  logic [DW-1:0] st_data, ld_data, dc_data;
  logic [BY-1:0] st_be, dc_be;
  logic ld_hit, overflow, dc_we, stall, done;

  always #4 clk = ~clk;

  spec_store_buf u_spec_store_buf (
    .clk_i(clk), .rst_ni(rst_n), .spec_i(spec), .st_valid_i(st_valid),
    .st_addr_i(st_addr), .st_data_i(st_data), .st_be_i(st_be),
    .abort_i(abort), .commit_i(commit), .ld_addr_i(ld_addr),
    .ld_cache_data_i(CACHE), .ld_data_o(ld_data), .ld_hit_o(ld_hit),
    .overflow_o(overflow), .dc_we_o(dc_we), .dc_addr_o(dc_addr),
    .dc_data_o(dc_data), .dc_be_o(dc_be), .coh_stall_o(stall),
    .commit_done_o(done)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  m;
  } wr_t;
  wr_t exp_q[$];
  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bmask(input logic [3:0] m);
    for (int b = 0; b < 4; b++) bmask[b*8 +: 8] = {8{m[b]}};
  endfunction

  function automatic wr_t mk(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
    wr_t w;
    w.a = a; w.d = d; w.m = m;
    return w;
  endfunction

  // scoreboard monitor for the cache write port
  always @(negedge clk) begin
    wr_t e;
    if (rst_n && dc_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected cache write addr", dc_addr, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(dc_addr == e.a, "R6", "write addr", dc_addr, e.a);
        chk((dc_data & bmask(e.m)) == (e.d & bmask(e.m)), "R6", "write data", dc_data, e.d);
        chk(dc_be == e.m, "R6", "write mask", {28'h0, dc_be}, {28'h0, e.m});
      end
    end
  end

  task automatic clr();
    st_valid = 1'b0; abort = 1'b0; commit = 1'b0;
  endtask

  task automatic st(input bit sp, input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
    @(posedge clk); #1;
    clr();
    spec = sp; st_valid = 1'b1; st_addr = a; st_data = d; st_be = m;
    @(negedge clk);
  endtask

  task automatic ld_chk(input logic [31:0] a, input bit eh, input logic [31:0] ed, input string req);
    @(posedge clk); #1;
    clr();
    ld_addr = a;
    @(negedge clk);
    chk(ld_hit == eh, req, "load hit", {31'h0, ld_hit}, {31'h0, eh});
    chk(ld_data == ed, req, "load data", ld_data, ed);
  endtask

  task automatic wait_done(input bit inject, output int nstall, output bit seen, output bit st_at_done);
    @(posedge clk); #1;
    clr();
    if (inject) begin
      abort = 1'b1; st_valid = 1'b1; spec = 1'b1;
      st_addr = 32'hC00; st_data = 32'h0C0C0C0C; st_be = 4'hF;
    end
    nstall = 0; seen = 1'b0; st_at_done = 1'b1;
    for (int k = 0; k < 16 && !seen; k++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        st_at_done = stall;
      end else if (stall) begin
        nstall++;
      end
      if (!seen) begin
        @(posedge clk); #1;
        clr();
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ns;
    bit sn, sd;
    spec = 1'b0; clr(); st_addr = '0; st_data = '0; st_be = '0; ld_addr = 32'hFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!stall, "R7", "stall after reset", {31'h0, stall}, 32'h0);
    chk(!done && !dc_we && !ld_hit, "R8", "idle outputs after reset", {29'h0, done, dc_we, ld_hit}, 32'h0);

    // R9 non-speculative bypass
    exp_q.push_back(mk(32'h100, 32'h11111111, 4'hF));
    st(1'b0, 32'h100, 32'h11111111, 4'hF);
    chk(dc_we, "R9", "bypass write enable", {31'h0, dc_we}, 32'h1);
    ld_chk(32'h100, 1'b0, CACHE, "R9");

    // R1 capture, R4 forwarding
    st(1'b1, 32'h200, 32'hAABBCCDD, 4'b0011);
    chk(!dc_we, "R1", "no cache write on spec store", {31'h0, dc_we}, 32'h0);
    ld_chk(32'h200, 1'b1, 32'hCAFECCDD, "R4");
    ld_chk(32'h2F0, 1'b0, CACHE, "R4");

    // R2 merge
    st(1'b1, 32'h200, 32'h12345678, 4'b0110);
    chk(!overflow, "R2", "merge no overflow", {31'h0, overflow}, 32'h0);
    ld_chk(32'h200, 1'b1, 32'hCA3456DD, "R2");

    // fill, R3 overflow
    st(1'b1, 32'h300, 32'h33333333, 4'hF);
    st(1'b1, 32'h400, 32'h44444444, 4'hF);
    st(1'b1, 32'h500, 32'h55555555, 4'b1000);
    chk(!overflow, "R3", "last free entry no overflow", {31'h0, overflow}, 32'h0);
    st(1'b1, 32'h600, 32'h66666666, 4'hF);
    chk(overflow, "R3", "overflow when full", {31'h0, overflow}, 32'h1);
    st(1'b1, 32'h200, 32'h000000EE, 4'b0001);
    chk(!overflow, "R2", "merge while full", {31'h0, overflow}, 32'h0);
    ld_chk(32'h600, 1'b0, CACHE, "R3");
    ld_chk(32'h200, 1'b1, 32'hCA3456EE, "R2");
    ld_chk(32'h500, 1'b1, 32'h55FEF00D, "R4");

    // R6 R7 R8 commit drain
    exp_q.push_back(mk(32'h200, 32'hAA3456EE, 4'b0111));
    exp_q.push_back(mk(32'h300, 32'h33333333, 4'hF));
    exp_q.push_back(mk(32'h400, 32'h44444444, 4'hF));
    exp_q.push_back(mk(32'h500, 32'h55555555, 4'b1000));
    @(posedge clk); #1; clr(); commit = 1'b1;
    wait_done(1'b0, ns, sn, sd);
    chk(ns == 4, "R7", "stall cycles", ns, 32'd4);
    chk(sn, "R8", "done pulse seen", {31'h0, sn}, 32'h1);
    chk(!sd, "R8", "stall low at done", {31'h0, sd}, 32'h0);
    chk(exp_q.size() == 0, "R6", "drain writes outstanding", exp_q.size(), 32'h0);
    ld_chk(32'h300, 1'b0, CACHE, "R8");

    // R5 abort beats store and commit
    st(1'b1, 32'h700, 32'h77777777, 4'hF);
    st(1'b1, 32'h800, 32'h88888888, 4'hF);
    @(posedge clk); #1; clr();
    abort = 1'b1; commit = 1'b1; st_valid = 1'b1; spec = 1'b1;
    st_addr = 32'h900; st_data = 32'h99999999; st_be = 4'hF;
    @(negedge clk);
    ld_chk(32'h700, 1'b0, CACHE, "R5");
    ld_chk(32'h900, 1'b0, CACHE, "R5");
    chk(!stall, "R5", "no drain after abort", {31'h0, stall}, 32'h0);
    @(posedge clk); #1; clr(); commit = 1'b1;
    wait_done(1'b0, ns, sn, sd);
    chk(sn && ns == 0, "R8", "empty commit done, stall cycles", ns, 32'h0);

    // R10 store with commit, injection during drain
    st(1'b1, 32'hA00, 32'h0A0A0A0A, 4'hF);
    exp_q.push_back(mk(32'hA00, 32'h0A0A0A0A, 4'hF));
    exp_q.push_back(mk(32'hB00, 32'h0B0B0B0B, 4'hF));
    @(posedge clk); #1; clr();
    commit = 1'b1; st_valid = 1'b1; spec = 1'b1;
    st_addr = 32'hB00; st_data = 32'h0B0B0B0B; st_be = 4'hF;
    wait_done(1'b1, ns, sn, sd);
    chk(ns == 2, "R10", "stall cycles with same-cycle store", ns, 32'd2);
    chk(sn && !sd, "R10", "drain completes despite abort", {31'h0, sn}, 32'h1);
    ld_chk(32'hC00, 1'b0, CACHE, "R10");
    ld_chk(32'hB00, 1'b0, CACHE, "R10");

    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R6", "writes outstanding at end", exp_q.size(), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule